// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block is a one-way word queue between two independent clock domains. A producer on the write clock pushes 36-bit words and a consumer on the read clock pops them in arrival order. The two clocks may be unrelated or may be the same clock. Each side transfers a word on a rising edge of its own clock only when its select input is low and its enable input is high. The effective handshake is a valid/ready pair: the producer's valid is select-low-and-enable-high. Its ready is "not full" in standard mode or input-ready in fall-through mode. The consumer works the same way against not-empty or output-ready. A request raised while ready is false is dropped, not queued, so a stalled side simply holds its request until the flag allows it.

A static mode input picks one of two read behaviours. In standard mode the side flags mean full and empty, and a granted read puts its word on the output after that read edge. In fall-through mode the side flags mean input-ready and output-ready. The oldest word is moved into the output register without any request, and each granted read moves the next word in. Active-low almost-full and almost-empty flags compare the fill level against offset inputs, each in its own clock domain. A two-way channel is built from two instances, one per direction. Pointers cross the clock boundary as gray code through two-stage synchronizers, so each flag reports a slightly stale view of the far side. The staleness always errs on the safe side.

Top module: `xfifo_top`

## Requirements
- R1: A write is taken only on a `wr_clk` edge with `wr_cs_n` low and `wr_en` high. A read is taken only on an `rd_clk` edge with `rd_cs_n` low and `rd_en` high. Any other combination leaves the stored contents, `rd_data` and the flags unchanged.
- R2: With `std_mode` high, `wr_flag` is 1 exactly when the storage holds DEPTH words, and `rd_flag` is 1 exactly when it holds none (both after synchronization settles).
- R3: With `std_mode` low, `rd_flag` is 1 exactly when a valid word is on `rd_data`. The oldest word reaches `rd_data` with no read request. `wr_flag` is 1 when the storage has a free slot. A word held on `rd_data` no longer occupies a storage slot, so DEPTH+1 words fit in total.
- R4: In standard mode a read granted on an edge shows its word on `rd_data` after that edge, and the word holds until the next granted read. In both modes words leave in the order they were written.
- R5: `wr_almost_full_n` is 0 when (DEPTH minus the words in storage) is less than or equal to `af_offset`, and 1 otherwise. It is computed in the write domain.
- R6: `rd_almost_empty_n` is 0 when the word count is less than or equal to `ae_offset`, and 1 otherwise. In fall-through mode the count includes a word waiting on `rd_data`. It is computed in the read domain.
- R7: A write while full (standard) or not input-ready (fall-through) is discarded. A read while empty or not output-ready is discarded. Neither pointer moves, and later traffic is unaffected.
- R8: `wr_rst` and `rd_rst` are synchronous and active high, one per domain. With both applied, the block holds no words and `rd_data` is 0. It reports not-full/input-ready on the write side and empty/not-output-ready on the read side.
- R9: Each pointer that crosses domains changes by at most one bit per clock of its own domain.
- R10: `std_mode` is held constant outside reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| std_mode | input | 1 | 1 = standard timing, 0 = fall-through timing; static |
| wr_clk | input | 1 | Write-side clock |
| wr_rst | input | 1 | Synchronous write-side reset, active high |
| wr_cs_n | input | 1 | Write select, active low |
| wr_en | input | 1 | Write enable, active high |
| wr_data | input | 36 | Word to store |
| af_offset | input | $clog2(DEPTH)+1 | Almost-full threshold in free slots |
| wr_flag | output | 1 | Full (standard) or input-ready (fall-through) |
| wr_almost_full_n | output | 1 | Almost-full, active low |
| rd_clk | input | 1 | Read-side clock |
| rd_rst | input | 1 | Synchronous read-side reset, active high |
| rd_cs_n | input | 1 | Read select, active low |
| rd_en | input | 1 | Read enable, active high |
| ae_offset | input | $clog2(DEPTH)+1 | Almost-empty threshold in words |
| rd_data | output | 36 | Output word register |
| rd_flag | output | 1 | Empty (standard) or output-ready (fall-through) |
| rd_almost_empty_n | output | 1 | Almost-empty, active low |

## Verification
The assertions rely on the mode input changing only while both resets are held. They also rely on each domain's reset starting high before the first edge, so that past values of the pointers are never taken from before reset. The bench changes mode only inside a reset window of several cycles on both clocks, and it starts with both resets high. It changes select, enable and data only on falling edges of the matching clock. After every write and every drain step it waits several cycles of both clocks before comparing flags, so every expectation is taken once the synchronizers have settled.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;
  localparam int DATA_W = 36;
  typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/xfifo_sync.sv
module xfifo_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage[0] <= '0;
        else     stage[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage[s] <= '0;
        else     stage[s] <= stage[s-1];
      end
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/xfifo_ram.sv
module xfifo_ram import xfifo_pkg::*; #(
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          wen,
  input  logic [AW-1:0] waddr,
  input  word_t         wdata,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          ren,
  input  logic [AW-1:0] raddr,
  output word_t         rdata
);
  word_t mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (wen) mem[waddr] <= wdata;
  end

  // registered read port doubles as the output word register
  always_ff @(posedge rclk) begin
    if (rrst)     rdata <= '0;
    else if (ren) rdata <= mem[raddr];
  end
endmodule

// File: rtl/xfifo_wr_side.sv
module xfifo_wr_side #(
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          en,
  input  logic          std_mode,
  input  logic [PW-1:0] af_offset,
  input  logic [PW-1:0] rgray_sync,
  output logic [PW-1:0] wgray,
  output logic [AW-1:0] waddr,
  output logic          wen,
  output logic          wr_flag,
  output logic          almost_full_n
);
  logic [PW-1:0] wbin, wnext, rbin_s, used, free;
  logic          full;

  always_comb begin
    for (int i = 0; i < PW; i++) rbin_s[i] = ^(rgray_sync >> i);
  end

  assign used          = wbin - rbin_s;
  assign full          = (used == PW'(DEPTH));
  assign free          = PW'(DEPTH) - used;
  assign wen           = !cs_n && en && !full;
  assign waddr         = wbin[AW-1:0];
  assign wnext         = wbin + PW'(1);
  assign wr_flag       = std_mode ? full : !full;
  assign almost_full_n = !(free <= af_offset);

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (wen) begin
      wbin  <= wnext;
      wgray <= wnext ^ (wnext >> 1);
    end
  end

  a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
    used <= PW'(DEPTH));
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
    full |=> $stable(wgray));
  a_r9_wgray_step: assert property (@(posedge clk) disable iff (rst)
    $countones(wgray ^ $past(wgray)) <= 1);
  a_r10_mode_static: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(std_mode));
endmodule

// File: rtl/xfifo_rd_side.sv
module xfifo_rd_side import xfifo_pkg::*; #(
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1,
  localparam int HW    = PW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          en,
  input  logic          std_mode,
  input  logic [PW-1:0] ae_offset,
  input  logic [PW-1:0] wgray_sync,
  input  word_t         rdata,
  output logic [PW-1:0] rgray,
  output logic [AW-1:0] raddr,
  output logic          ren,
  output logic          rd_flag,
  output logic          almost_empty_n
);
  logic [PW-1:0] rbin, rnext, wbin_s, ram_cnt;
  logic [HW-1:0] held;
  logic          ram_empty, ov, take;

  always_comb begin
    for (int i = 0; i < PW; i++) wbin_s[i] = ^(wgray_sync >> i);
  end

  assign ram_cnt        = wbin_s - rbin;
  assign ram_empty      = (ram_cnt == '0);
  assign take           = !cs_n && en && (std_mode ? !ram_empty : ov);
  // fall-through: refill the output register whenever it is free or being taken
  assign ren            = std_mode ? take : (!ram_empty && (!ov || take));
  assign raddr          = rbin[AW-1:0];
  assign rnext          = rbin + PW'(1);
  assign held           = {1'b0, ram_cnt} + HW'(ov);
  assign rd_flag        = std_mode ? ram_empty : ov;
  assign almost_empty_n = !(held <= {1'b0, ae_offset});

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin  <= '0;
      rgray <= '0;
      ov    <= 1'b0;
    end else begin
      if (ren) begin
        rbin  <= rnext;
        rgray <= rnext ^ (rnext >> 1);
      end
      if (!std_mode) begin
        if (ren)       ov <= 1'b1;
        else if (take) ov <= 1'b0;
      end
    end
  end

  a_r7_no_underflow: assert property (@(posedge clk) disable iff (rst)
    (std_mode && ram_empty) |=> $stable(rgray));
  a_r3_word_held: assert property (@(posedge clk) disable iff (rst)
    (!std_mode && ov && !take) |=> (ov && $stable(rdata)));
  a_r4_std_hold: assert property (@(posedge clk) disable iff (rst)
    (std_mode && !take) |=> $stable(rdata));
  a_r9_rgray_step: assert property (@(posedge clk) disable iff (rst)
    $countones(rgray ^ $past(rgray)) <= 1);
endmodule

// File: rtl/xfifo_top.sv
module xfifo_top import xfifo_pkg::*; #(
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic          std_mode,
  input  logic          wr_clk,
  input  logic          wr_rst,
  input  logic          wr_cs_n,
  input  logic          wr_en,
  input  logic [35:0]   wr_data,
  input  logic [PW-1:0] af_offset,
  output logic          wr_flag,
  output logic          wr_almost_full_n,
  input  logic          rd_clk,
  input  logic          rd_rst,
  input  logic          rd_cs_n,
  input  logic          rd_en,
  input  logic [PW-1:0] ae_offset,
  output logic [35:0]   rd_data,
  output logic          rd_flag,
  output logic          rd_almost_empty_n
);
  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
  logic [AW-1:0] waddr, raddr;
  logic          wen, ren;

  xfifo_wr_side #(.DEPTH(DEPTH)) u_wr (
    .clk(wr_clk), .rst(wr_rst), .cs_n(wr_cs_n), .en(wr_en),
    .std_mode(std_mode), .af_offset(af_offset), .rgray_sync(rgray_s),
    .wgray(wgray), .waddr(waddr), .wen(wen), .wr_flag(wr_flag),
    .almost_full_n(wr_almost_full_n)
  );

  xfifo_sync #(.W(PW), .STAGES(2)) u_w2r (
    .clk(rd_clk), .rst(rd_rst), .d(wgray), .q(wgray_s)
  );

  xfifo_sync #(.W(PW), .STAGES(2)) u_r2w (
    .clk(wr_clk), .rst(wr_rst), .d(rgray), .q(rgray_s)
  );

  xfifo_ram #(.DEPTH(DEPTH)) u_ram (
    .wclk(wr_clk), .wen(wen), .waddr(waddr), .wdata(wr_data),
    .rclk(rd_clk), .rrst(rd_rst), .ren(ren), .raddr(raddr), .rdata(rd_data)
  );

  xfifo_rd_side #(.DEPTH(DEPTH)) u_rd (
    .clk(rd_clk), .rst(rd_rst), .cs_n(rd_cs_n), .en(rd_en),
    .std_mode(std_mode), .ae_offset(ae_offset), .wgray_sync(wgray_s),
    .rdata(rd_data), .rgray(rgray), .raddr(raddr), .ren(ren),
    .rd_flag(rd_flag), .almost_empty_n(rd_almost_empty_n)
  );
endmodule

// File: tb/xfifo_top_tb.sv
module xfifo_top_tb;
  localparam int DEPTH = 8;
  localparam int PW    = 4;

  logic          std_mode = 1'b1;
  logic          wr_clk = 1'b0, rd_clk = 1'b0;
  logic          wr_rst = 1'b1, rd_rst = 1'b1;
  logic          wr_cs_n = 1'b1, wr_en = 1'b0;
  logic [35:0]   wr_data = '0;
  logic [PW-1:0] af_offset = '0, ae_offset = '0;
  logic          rd_cs_n = 1'b1, rd_en = 1'b0;
  logic [35:0]   rd_data;
  logic          wr_flag, wr_almost_full_n, rd_flag, rd_almost_empty_n;

  int  checks = 0, failures = 0;
  bit  done = 0;

  always #2.5 wr_clk = ~wr_clk;
  always #3.5 rd_clk = ~rd_clk;

  xfifo_top #(.DEPTH(DEPTH)) u_dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(posedge rd_clk);
    repeat (6) @(posedge wr_clk);
    repeat (2) @(posedge rd_clk);
  endtask

  task automatic do_write(input logic cs_n, input logic en, input logic [35:0] d);
    @(negedge wr_clk);
    wr_cs_n = cs_n; wr_en = en; wr_data = d;
    @(negedge wr_clk);
    wr_cs_n = 1'b1; wr_en = 1'b0;
  endtask

  task automatic do_read(input logic cs_n, input logic en);
    @(negedge rd_clk);
    rd_cs_n = cs_n; rd_en = en;
    @(negedge rd_clk);
    rd_cs_n = 1'b1; rd_en = 1'b0;
  endtask

  task automatic reset_both(input logic mode);
    @(negedge wr_clk);
    wr_rst = 1'b1; rd_rst = 1'b1;
    repeat (3) @(negedge rd_clk);
    std_mode = mode;
    repeat (4) @(negedge rd_clk);
    repeat (4) @(negedge wr_clk);
    wr_rst = 1'b0; rd_rst = 1'b0;
    settle();
  endtask

  function automatic logic [35:0] pat(input int m, input int n, input int i);
    return 36'h800000000 * m + 36'h1000 * n + 36'(i) + 36'h5;
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int m = 1; m >= 0; m--) begin
      int cap;
      cap = (m == 1) ? DEPTH : DEPTH + 1;
      for (int n = 0; n <= cap; n++) begin
        int ram;
        logic [35:0] prev;
        reset_both(m[0]);
        // R8: reset state
        chk("R8 rd_data", rd_data, 0);
        chk("R8 wr_flag", wr_flag, (m == 1) ? 0 : 1);
        chk("R8 rd_flag", rd_flag, (m == 1) ? 1 : 0);
        // fill, with ignored attempts before every write (R1)
        for (int i = 0; i < n; i++) begin
          do_write(1'b1, 1'b1, 36'hBAD000001);
          do_write(1'b0, 1'b0, 36'hBAD000002);
          do_write(1'b0, 1'b1, pat(m, n, i));
          settle();
        end
        if (n == cap) begin
          do_write(1'b0, 1'b1, 36'hBAD0000FF); // R7 overflow attempt
          settle();
        end
        ram = (m == 1) ? n : ((n > 0) ? n - 1 : 0);
        chk((m == 1) ? "R2 wr_flag" : "R3 wr_flag", wr_flag,
            (m == 1) ? ((ram == DEPTH) ? 1 : 0) : ((ram < DEPTH) ? 1 : 0));
        chk((m == 1) ? "R2 rd_flag" : "R3 rd_flag", rd_flag,
            (m == 1) ? ((n == 0) ? 1 : 0) : ((n > 0) ? 1 : 0));
        // R5 / R6: sweep offsets
        for (int off = 0; off <= DEPTH; off++) begin
          @(negedge wr_clk);
          af_offset = PW'(off); ae_offset = PW'(off);
          #1;
          chk("R5 almost_full_n", wr_almost_full_n, ((DEPTH - ram) <= off) ? 0 : 1);
          chk("R6 almost_empty_n", rd_almost_empty_n, (n <= off) ? 0 : 1);
        end
        // drain
        prev = '0;
        for (int i = 0; i < n; i++) begin
          if (m == 1) begin
            chk("R2 not empty", rd_flag, 0);
            do_read(1'b1, 1'b1);
            chk("R1 rd_data held", rd_data, prev);
            do_read(1'b0, 1'b1);
            chk("R4 order", rd_data, pat(m, n, i));
            prev = pat(m, n, i);
          end else begin
            chk("R3 output ready", rd_flag, 1);
            chk("R3 fall-through word", rd_data, pat(m, n, i));
            do_read(1'b0, 1'b0);
            chk("R1 word kept", rd_data, pat(m, n, i));
            do_read(1'b0, 1'b1);
          end
        end
        settle();
        chk((m == 1) ? "R2 empty after drain" : "R3 not ready after drain",
            rd_flag, (m == 1) ? 1 : 0);
        do_read(1'b0, 1'b1); // R7 underflow attempt
        if (m == 1) chk("R7 rd_data after empty read", rd_data, prev);
        do_write(1'b0, 1'b1, 36'h0CAFE0000 + 36'(n));
        settle();
        if (m == 1) begin
          chk("R7 not empty", rd_flag, 0);
          do_read(1'b0, 1'b1);
          chk("R7 next word", rd_data, 36'h0CAFE0000 + 36'(n));
        end else begin
          chk("R7 ready", rd_flag, 1);
          chk("R7 next word", rd_data, 36'h0CAFE0000 + 36'(n));
          do_read(1'b0, 1'b1);
        end
        settle();
        chk("R7 empty at end", rd_flag, (m == 1) ? 1 : 0);
      end
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule